// File: doc/BRIEF.md
# Banked Dual Data Pointer

This block keeps two independent 16-bit data pointers for external data memory and a one-bit selector that picks which of them is active. Software sees only one pair of byte registers, a high byte and a low byte, on the special-function-register (SFR) bus. Both bytes always map onto whichever pointer the selector currently names. The selector itself lives in bit 0 of an auxiliary register. The active pointer drives a 16-bit address output that the external bus cycle uses.

The core can also act on the pointers directly. It can step the active pointer by one, load all 16 bits of it in one cycle, and issue an increment of the auxiliary register. That increment only flips the selector. Because the selector toggles instead of being forced, a block-copy loop can alternate between a source pointer and a destination pointer without knowing which one it started on.

The selector is a two-state machine with states SEL_P0 and SEL_P1. From either state:
- transition LOAD_SEL follows an auxiliary-register write and moves to the state named by the written bit 0;
- transition FLIP follows an auxiliary increment and moves to the other state;
- with neither event the state is held.

Top module: `ddp_bank`

## Requirements
- R1: While reset is low and in the first cycle after it, both pointers read 0000h and the selector is 0 (SEL_P0).
- R2: An SFR write to 82h replaces bits 7:0 of the selected pointer, and a write to 83h replaces bits 15:8. The other byte of that pointer and the whole unselected pointer are unchanged.
- R3: The read data is combinational. Address 82h returns bits 7:0 of the selected pointer, 83h returns bits 15:8, and A2h returns the selector in bit 0 with bits 7:1 at 0. Any other address returns 00h.
- R4: An SFR write to A2h sets the selector to bit 0 of the written byte from the next cycle onward. The selector is otherwise held unless an auxiliary increment occurs.
- R5: An auxiliary increment toggles the selector (0 to 1, 1 to 0). If an SFR write to A2h happens in the same cycle, the write decides the new value.
- R6: A pointer increment adds one to the selected pointer only. The unselected pointer keeps its value.
- R7: Incrementing a pointer that holds FFFFh gives 0000h.
- R8: A load command writes the 16-bit load value into the selected pointer only.
- R9: The operations on the selected pointer have a fixed priority: an SFR byte write (82h/83h) wins over a load, and a load wins over an increment. The losing commands of that cycle have no effect.
- R10: The address output always equals the currently selected pointer. After the selector changes, the output shows the other pointer in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for sfr_addr |
| aux_inc | input | 1 | Increment of the auxiliary register (flips the selector) |
| ptr_inc | input | 1 | Increment the selected pointer |
| ptr_load | input | 1 | Load the selected pointer from load_value |
| load_value | input | 16 | Value for ptr_load |
| mem_addr | output | 16 | Selected pointer, used as the external data address |
| sel_out | output | 1 | Current selector value |

## Verification
The assertions assume that every input is a known value, stays stable across each rising edge, and changes only between edges. They also assume that a byte write, a load and an increment may all arrive in the same cycle, and that the priority rules settle the outcome. The stimulus meets these assumptions by driving every input on the falling edge from known constants or from random values. It deliberately piles several commands into one cycle, including a selector change together with a pointer operation, so the priority and same-cycle corners are exercised.

// File: rtl/ddp_pkg.sv
package ddp_pkg;

    typedef enum logic {
        SEL_P0 = 1'b0,
        SEL_P1 = 1'b1
    } sel_state_t;

    typedef enum logic [2:0] {
        PTR_HOLD,
        PTR_WR_LO,
        PTR_WR_HI,
        PTR_LOAD,
        PTR_STEP
    } ptr_op_t;

endpackage

// File: rtl/ddp_select_fsm.sv
module ddp_select_fsm
    import ddp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic aux_wr,
    input  logic aux_wbit,
    input  logic aux_inc,
    output logic sel
);

    sel_state_t state_q;
    sel_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_P0;
        else        state_q <= state_d;
    end

    // LOAD_SEL has priority over FLIP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_P0: begin
                if (aux_wr)       state_d = aux_wbit ? SEL_P1 : SEL_P0;
                else if (aux_inc) state_d = SEL_P1;
            end
            SEL_P1: begin
                if (aux_wr)       state_d = aux_wbit ? SEL_P1 : SEL_P0;
                else if (aux_inc) state_d = SEL_P0;
            end
        endcase
    end

    always_comb begin
        sel = (state_q == SEL_P1);
    end

endmodule

// File: rtl/ddp_ptr_reg.sv
module ddp_ptr_reg
    import ddp_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PTR_W = 2 * BYTE_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  ptr_op_t           op,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [PTR_W-1:0]  load_in,
    output logic [PTR_W-1:0]  ptr
);

    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr;
        unique case (op)
            PTR_HOLD:  ptr_d = ptr;
            PTR_WR_LO: ptr_d = {ptr[PTR_W-1:BYTE_W], byte_in};
            PTR_WR_HI: ptr_d = {byte_in, ptr[BYTE_W-1:0]};
            PTR_LOAD:  ptr_d = load_in;
            PTR_STEP:  ptr_d = ptr + PTR_W'(1);
            default:   ptr_d = ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_d;
    end

endmodule

// File: rtl/ddp_bank.sv
module ddp_bank
    import ddp_pkg::*;
#(
    parameter int              BYTE_W   = 8,
    parameter logic [7:0]      LO_ADDR  = 8'h82,
    parameter logic [7:0]      HI_ADDR  = 8'h83,
    parameter logic [7:0]      AUX_ADDR = 8'hA2,
    localparam int             PTR_W    = 2 * BYTE_W,
    localparam int             NUM_PTR  = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [BYTE_W-1:0] sfr_wdata,
    output logic [BYTE_W-1:0] sfr_rdata,
    input  logic              aux_inc,
    input  logic              ptr_inc,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  load_value,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              sel_out
);

    logic             sel;
    logic             aux_wr;
    ptr_op_t          op_common;
    logic [PTR_W-1:0] ptr_q [NUM_PTR];

    assign aux_wr = sfr_wr && (sfr_addr == AUX_ADDR);

    ddp_select_fsm u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .aux_wr   (aux_wr),
        .aux_wbit (sfr_wdata[0]),
        .aux_inc  (aux_inc),
        .sel      (sel)
    );

    // byte write > load > step
    always_comb begin
        if (sfr_wr && sfr_addr == LO_ADDR)      op_common = PTR_WR_LO;
        else if (sfr_wr && sfr_addr == HI_ADDR) op_common = PTR_WR_HI;
        else if (ptr_load)                      op_common = PTR_LOAD;
        else if (ptr_inc)                       op_common = PTR_STEP;
        else                                    op_common = PTR_HOLD;
    end

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        ptr_op_t op_i;
        assign op_i = (sel == 1'(i)) ? op_common : PTR_HOLD;

        ddp_ptr_reg #(.BYTE_W(BYTE_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op_i),
            .byte_in (sfr_wdata),
            .load_in (load_value),
            .ptr     (ptr_q[i])
        );
    end

    always_comb begin
        mem_addr = ptr_q[sel];
        sel_out  = sel;
        if (sfr_addr == LO_ADDR)       sfr_rdata = mem_addr[BYTE_W-1:0];
        else if (sfr_addr == HI_ADDR)  sfr_rdata = mem_addr[PTR_W-1:BYTE_W];
        else if (sfr_addr == AUX_ADDR) sfr_rdata = {{(BYTE_W-1){1'b0}}, sel};
        else                           sfr_rdata = '0;
    end

endmodule

// File: rtl/ddp_bank_chk.sv
module ddp_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  sfr_addr,
    input logic        sfr_wr,
    input logic [7:0]  sfr_wdata,
    input logic [7:0]  sfr_rdata,
    input logic        aux_inc,
    input logic        ptr_inc,
    input logic        ptr_load,
    input logic [15:0] load_value,
    input logic [15:0] mem_addr,
    input logic        sel_out
);

    logic aux_w, byte_w, sel_move;
    assign aux_w    = sfr_wr && sfr_addr == 8'hA2;
    assign byte_w   = sfr_wr && (sfr_addr == 8'h82 || sfr_addr == 8'h83);
    assign sel_move = aux_w || aux_inc;

    AST_AUX_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        aux_w |=> sel_out == $past(sfr_wdata[0])); // R4
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_move |=> $stable(sel_out)); // R4
    AST_AUX_INC_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_inc && !aux_w) |=> sel_out != $past(sel_out)); // R5
    AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_load && !byte_w && !sel_move) |=> mem_addr == $past(mem_addr) + 16'd1); // R7
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !byte_w && !sel_move) |=> mem_addr == $past(load_value)); // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load && !ptr_inc && !sfr_wr && !aux_inc) |=> $stable(mem_addr)); // R10
    AST_READ_AUX: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_addr == 8'hA2 |-> sfr_rdata == {7'b0, sel_out}); // R3
    AST_READ_HI: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_addr == 8'h83 |-> sfr_rdata == mem_addr[15:8]); // R3

endmodule

bind ddp_bank ddp_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfr_addr   (sfr_addr),
    .sfr_wr     (sfr_wr),
    .sfr_wdata  (sfr_wdata),
    .sfr_rdata  (sfr_rdata),
    .aux_inc    (aux_inc),
    .ptr_inc    (ptr_inc),
    .ptr_load   (ptr_load),
    .load_value (load_value),
    .mem_addr   (mem_addr),
    .sel_out    (sel_out)
);

// File: tb/ddp_bank_tb.sv
`timescale 1ns/100ps
module ddp_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        aux_inc = 1'b0;
    logic        ptr_inc = 1'b0;
    logic        ptr_load = 1'b0;
    logic [15:0] load_value = 16'h0000;
    logic [15:0] mem_addr;
    logic        sel_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_tag = "R1";

    int m_ptr [2];
    int m_sel;

    always #2.5 clk = ~clk;

    ddp_bank u_dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .aux_inc(aux_inc),
        .ptr_inc(ptr_inc), .ptr_load(ptr_load), .load_value(load_value),
        .mem_addr(mem_addr), .sel_out(sel_out)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rdata();
        if (sfr_addr == 8'h82) return m_ptr[m_sel] & 'hFF;
        if (sfr_addr == 8'h83) return (m_ptr[m_sel] >> 8) & 'hFF;
        if (sfr_addr == 8'hA2) return m_sel;
        return 0;
    endfunction

    task automatic model_step();
        int p;
        if (!rst_n) begin
            m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0;
            return;
        end
        p = m_ptr[m_sel];
        if (sfr_wr && sfr_addr == 8'h82)      p = (p & 'hFF00) | int'(sfr_wdata);
        else if (sfr_wr && sfr_addr == 8'h83) p = (p & 'h00FF) | (int'(sfr_wdata) << 8);
        else if (ptr_load)                    p = int'(load_value);
        else if (ptr_inc)                     p = (p + 1) % 65536;
        m_ptr[m_sel] = p;
        if (sfr_wr && sfr_addr == 8'hA2) m_sel = int'(sfr_wdata[0]);
        else if (aux_inc)                m_sel = 1 - m_sel;
    endtask

    // inputs applied on a falling edge; compare, update model, wait next falling edge
    task automatic cyc(input logic [7:0] a, input logic w, input logic [7:0] d,
                       input logic ai, input logic pi, input logic pl, input logic [15:0] lv);
        sfr_addr = a; sfr_wr = w; sfr_wdata = d;
        aux_inc = ai; ptr_inc = pi; ptr_load = pl; load_value = lv;
        #1;
        check(cur_tag, "sel_out", int'(sel_out), m_sel);
        check(cur_tag, "mem_addr", int'(mem_addr), m_ptr[m_sel]);
        check(cur_tag, "sfr_rdata", int'(sfr_rdata), exp_rdata());
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(input logic [7:0] a);
        cyc(a, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000);
    endtask

    initial begin
        m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0;
        @(negedge clk);
        cur_tag = "R1";
        cyc(8'h82, 1'b1, 8'h55, 1'b1, 1'b1, 1'b1, 16'h1234);
        cyc(8'h83, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000);
        rst_n = 1'b1;
        idle(8'hA2);
        idle(8'h83);

        cur_tag = "R2";
        cyc(8'h82, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 16'h0);
        cyc(8'h83, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 16'h0);
        idle(8'h82);
        idle(8'h83);

        cur_tag = "R4";
        cyc(8'hA2, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0);
        idle(8'hA2);
        cyc(8'h83, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 16'h0);
        idle(8'h83);
        cyc(8'hA2, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 16'h0);
        idle(8'h83);

        cur_tag = "R3";
        idle(8'h00);
        idle(8'h81);
        idle(8'hA3);
        idle(8'h82);

        cur_tag = "R5";
        cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
        idle(8'hA2);
        cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
        idle(8'hA2);
        cyc(8'hA2, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
        idle(8'hA2);

        cur_tag = "R6";
        cyc(8'h82, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0);
        cyc(8'h82, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0);
        cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
        idle(8'h83);

        cur_tag = "R7";
        cyc(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hFFFF);
        cyc(8'h82, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0);
        idle(8'h83);

        cur_tag = "R8";
        cyc(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hBEEF);
        cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
        cyc(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0F0F);
        idle(8'h82);

        cur_tag = "R9";
        cyc(8'h82, 1'b1, 8'h99, 1'b0, 1'b1, 1'b1, 16'h4444);
        idle(8'h82);
        cyc(8'h83, 1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 16'h0);
        idle(8'h83);
        cyc(8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 16'h2222);
        idle(8'h82);

        cur_tag = "R10";
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            case ($urandom % 5)
                0: a = 8'h82;
                1: a = 8'h83;
                2: a = 8'hA2;
                3: a = 8'h00;
                default: a = 8'($urandom);
            endcase
            cyc(a, 1'($urandom % 3 == 0), 8'($urandom), 1'($urandom % 4 == 0),
                1'($urandom % 2), 1'($urandom % 5 == 0),
                ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule